// File: doc/BRIEF.md
# Cache Way Replacement Selector

This block chooses which way of a set-associative cache is evicted when a line has to be refilled. It serves caches with one to four ways. The cache controller gives it the line index on every cycle, together with a strobe for each lookup that hits and a strobe for each refill. It also gives the way being touched and a per-way lock mask for that index. One clock later the block returns the victim way for that index. Tag compare, data storage and memory traffic stay with the controller.

There are three policies, and a parameter picks one. The pseudo-random policy draws the victim from a free-running counter. The least-recently-replaced policy is legal only for two ways. It keeps one bit per line and always points at the way that was filled longer ago. The least-recently-used policy keeps, per line, the full recency order of the ways as a compact code: 1 bit for two ways, 3 bits for three and 5 bits for four. Every lookup and every refill moves the touched way to the most recent place. When locking is enabled, a locked way is skipped and the next candidate in the policy's order is taken. When all ways are locked, a no-victim flag is raised.

Top module: `way_victim_sel`

## Requirements
- R1: `victim_o` is always below NUM_WAYS. With NUM_WAYS = 1 it is always 0.
- R2: Outputs are registered. The decision seen after rising edge k uses the inputs present before edge k and the per-line state as it was before any update made at edge k.
- R3: Random policy: a counter starts at 0 after reset and advances by one on every clock. It wraps after NUM_WAYS-1, so three ways give the sequence 0,1,2,0. The unlocked candidate is the counter value.
- R4: Least-recently-replaced policy: a refill of way w at an index makes way 1-w the next victim at that index. A lookup strobe without a refill leaves the state unchanged.
- R5: LRU policy: the victim is the way touched least recently at that index. A lookup strobe and a refill strobe each count as a touch of `way_i`.
- R6: Reset drives `victim_o` and `no_victim_o` to 0 and clears the counter. Every line's LRU order becomes way 0 least recent up to the top way most recent. Every replaced-bit points at way 0.
- R7: A way whose `lock_i` bit is 1 is never the victim, and the fallback order depends on the policy. Random takes the counter value, then counts upward modulo NUM_WAYS. Least-recently-replaced takes the other way. LRU takes the next-older way in the order.
- R8: When every way at the index is locked, `no_victim_o` is 1 and `victim_o` is 0. Strobes in that cycle still update the per-line state.
- R9: With LOCK_EN = 0, `lock_i` has no effect on the victim, and `no_victim_o` stays 0.
- R10: Strobes at one index never change the state seen at any other index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| line_idx_i | input | IDX_W | Line index looked up this cycle |
| access_i | input | 1 | Lookup hit on `way_i` at `line_idx_i` |
| fill_i | input | 1 | Refill of `way_i` at `line_idx_i` |
| way_i | input | WAY_W | Way being touched |
| lock_i | input | NUM_WAYS | Lock bit of each way at `line_idx_i` |
| victim_o | output | WAY_W | Victim way, registered |
| no_victim_o | output | 1 | All ways locked, registered |

## Verification
Each result appears one clock after its stimulus: `victim_o` and `no_victim_o` take the value computed from the inputs and the line state present before a rising edge. A strobe at that edge changes the outcome only from the next edge onward. The bench drives inputs on the falling edge and computes the expected victim from its own per-line models before advancing them. It then compares on the next falling edge, so every check lands exactly in the cycle its result is due.

// File: rtl/wvs_pkg.sv
package wvs_pkg;
  localparam int POL_RANDOM = 0;
  localparam int POL_LRR    = 1;
  localparam int POL_LRU    = 2;

  typedef logic [1:0] way_t;
  typedef way_t [3:0] order_t;  // [0] least recent .. [n-1] most recent

  function automatic int fact(input int n);
    case (n)
      0, 1:    return 1;
      2:       return 2;
      3:       return 6;
      default: return 24;
    endcase
  endfunction

  function automatic order_t identity_order();
    order_t o;
    for (int i = 0; i < 4; i++) o[i] = way_t'(i);
    return o;
  endfunction

  // Rank code (factorial base) -> recency order
  function automatic order_t lru_decode(input logic [4:0] code, input int n);
    order_t     o;
    logic [3:0] used;
    int         rem, f, d, cnt;
    o    = identity_order();
    used = '0;
    rem  = int'(code);
    for (int i = 0; i < 4; i++) begin
      if (i < n) begin
        f   = fact(n - 1 - i);
        d   = rem / f;
        rem = rem % f;
        cnt = 0;
        for (int w = 0; w < 4; w++) begin
          if (w < n && !used[w]) begin
            if (cnt == d) o[i] = way_t'(w);
            cnt++;
          end
        end
        used[o[i]] = 1'b1;
      end
    end
    return o;
  endfunction

  function automatic logic [4:0] lru_encode(input order_t o, input int n);
    logic [3:0] used;
    int         code, d;
    used = '0;
    code = 0;
    for (int i = 0; i < 4; i++) begin
      if (i < n) begin
        d = 0;
        for (int w = 0; w < 4; w++)
          if (w < n && !used[w] && way_t'(w) < o[i]) d++;
        code       = code + d * fact(n - 1 - i);
        used[o[i]] = 1'b1;
      end
    end
    return 5'(code);
  endfunction

  // Move way w to the most recent place
  function automatic order_t lru_touch(input order_t o, input way_t w, input int n);
    order_t r;
    int     j;
    r = identity_order();
    j = 0;
    for (int i = 0; i < 4; i++) begin
      if (i < n && o[i] != w) begin
        r[j] = o[i];
        j++;
      end
    end
    r[n - 1] = w;
    return r;
  endfunction
endpackage

// File: rtl/wvs_rand_ctr.sv
module wvs_rand_ctr #(
  parameter int NUM_WAYS = 4,
  parameter int WAY_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WAY_W-1:0] ctr_o
);
  localparam logic [WAY_W-1:0] LAST = WAY_W'(NUM_WAYS - 1);

  always_ff @(posedge clk) begin
    if (rst)                ctr_o <= '0;
    else if (ctr_o == LAST) ctr_o <= '0;
    else                    ctr_o <= ctr_o + 1'b1;
  end

  // R3
  ctr_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(ctr_o) < NUM_WAYS);

  // R3
  ctr_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ctr_o == (($past(ctr_o) == LAST) ? '0 : $past(ctr_o) + 1'b1)));
endmodule

// File: rtl/wvs_state_mem.sv
module wvs_state_mem #(
  parameter int NUM_LINES  = 16,
  parameter int IDX_W      = 4,
  parameter int ST_W       = 5,
  parameter int CODE_LIMIT = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ST_W-1:0]  rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ST_W-1:0]  wr_data
);
  logic [ST_W-1:0] mem [NUM_LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_LINES; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];

  // R5
  code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> int'(wr_data) < CODE_LIMIT);

  // R10
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && rd_idx == $past(rd_idx)) |-> $stable(rd_data));
endmodule

// File: rtl/wvs_pick.sv
module wvs_pick #(
  parameter int NUM_WAYS = 4,
  parameter int WAY_W    = 2
) (
  input  wvs_pkg::order_t      pref_i,
  input  logic [NUM_WAYS-1:0]  lock_i,
  output logic [WAY_W-1:0]     victim_o,
  output logic                 none_o
);
  import wvs_pkg::*;
  logic [3:0] lk;
  way_t       v;

  always_comb begin
    lk                 = '1;
    lk[NUM_WAYS-1:0]   = lock_i;
    v                  = '0;
    none_o             = 1'b1;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (!lk[pref_i[i]]) begin
        v      = pref_i[i];
        none_o = 1'b0;
      end
    end
    victim_o = WAY_W'(v);
  end
endmodule

// File: rtl/way_victim_sel.sv
module way_victim_sel #(
  parameter int NUM_WAYS  = 4,
  parameter int NUM_LINES = 16,
  parameter int POLICY    = wvs_pkg::POL_LRU,
  parameter int LOCK_EN   = 1,
  localparam int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IDX_W-1:0]    line_idx_i,
  input  logic                access_i,
  input  logic                fill_i,
  input  logic [WAY_W-1:0]    way_i,
  input  logic [NUM_WAYS-1:0] lock_i,
  output logic [WAY_W-1:0]    victim_o,
  output logic                no_victim_o
);
  import wvs_pkg::*;

  localparam int ST_W = (POLICY == POL_LRU) ?
                        ((NUM_WAYS == 4) ? 5 : (NUM_WAYS == 3) ? 3 : 1) : 1;
  localparam int CODE_LIMIT = (POLICY == POL_LRU) ? fact(NUM_WAYS) : 2;

  generate
    if (POLICY == POL_LRR && NUM_WAYS != 2) begin : g_bad_cfg
      $error("least-recently-replaced policy needs exactly two ways");
    end
  endgenerate

  logic [WAY_W-1:0]    ctr;
  logic [ST_W-1:0]     st_rd, st_wr;
  logic                st_we;
  logic [NUM_WAYS-1:0] lock_eff;
  order_t              pref;
  logic [WAY_W-1:0]    pick_v;
  logic                pick_none;
  logic                nb;

  wvs_rand_ctr #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_ctr (
    .clk(clk), .rst(rst), .ctr_o(ctr)
  );

  wvs_state_mem #(
    .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .ST_W(ST_W), .CODE_LIMIT(CODE_LIMIT)
  ) u_mem (
    .clk(clk), .rst(rst),
    .rd_idx(line_idx_i), .rd_data(st_rd),
    .wr_en(st_we), .wr_idx(line_idx_i), .wr_data(st_wr)
  );

  assign lock_eff = (LOCK_EN != 0) ? lock_i : '0;

  // Preference order of candidates, best first
  always_comb begin
    pref = identity_order();
    if (POLICY == POL_RANDOM) begin
      for (int i = 0; i < 4; i++) pref[i] = way_t'((int'(ctr) + i) % NUM_WAYS);
    end else if (POLICY == POL_LRR) begin
      pref[0] = {1'b0, st_rd[0]};
      pref[1] = {1'b0, ~st_rd[0]};
    end else begin
      pref = lru_decode(5'(st_rd), NUM_WAYS);
    end
  end

  // Per-line state update
  always_comb begin
    nb = ~way_i[0];
    if (POLICY == POL_LRU) begin
      st_we = access_i | fill_i;
      st_wr = ST_W'(lru_encode(lru_touch(pref, way_t'(way_i), NUM_WAYS), NUM_WAYS));
    end else if (POLICY == POL_LRR) begin
      st_we = fill_i;
      st_wr = ST_W'(nb);
    end else begin
      st_we = 1'b0;
      st_wr = '0;
    end
  end

  wvs_pick #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_pick (
    .pref_i(pref), .lock_i(lock_eff), .victim_o(pick_v), .none_o(pick_none)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      victim_o    <= '0;
      no_victim_o <= 1'b0;
    end else begin
      victim_o    <= pick_v;
      no_victim_o <= pick_none;
    end
  end

  // R1
  victim_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(victim_o) < NUM_WAYS);

  // R8
  no_victim_chk: assert property (@(posedge clk) disable iff (rst)
    no_victim_o |-> (victim_o == '0 && (&$past(lock_eff))));

  // R7
  unlocked_victim_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !no_victim_o) |->
      ((NUM_WAYS'(1) << victim_o) & $past(lock_eff)) == '0);

  // R9
  lock_off_chk: assert property (@(posedge clk) disable iff (rst)
    (LOCK_EN == 0) |-> !no_victim_o);
endmodule

// File: tb/way_victim_sel_tb.sv
module way_victim_sel_tb_top;
  import wvs_pkg::*;

  localparam int LINES = 8;
  localparam int IW    = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [IW-1:0] idx = '0;
  logic          acc = 1'b0, fill = 1'b0;
  logic [1:0]    w4 = '0, w3 = '0;
  logic          w2 = 1'b0;
  logic [3:0]    lk = '0;

  logic [1:0] v4, v3, vn;
  logic [0:0] v2, vd;
  logic       n4, n3, n2, nn, nd;

  int  ord [LINES][4];
  int  lrrb [LINES];
  int  c3, c4;
  int  errors = 0, checks = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  way_victim_sel #(.NUM_WAYS(4), .NUM_LINES(LINES), .POLICY(POL_LRU), .LOCK_EN(1)) dut_i (
    .clk(clk), .rst(rst), .line_idx_i(idx), .access_i(acc), .fill_i(fill),
    .way_i(w4), .lock_i(lk), .victim_o(v4), .no_victim_o(n4));

  way_victim_sel #(.NUM_WAYS(2), .NUM_LINES(LINES), .POLICY(POL_LRR), .LOCK_EN(1)) dut_lrr_i (
    .clk(clk), .rst(rst), .line_idx_i(idx), .access_i(acc), .fill_i(fill),
    .way_i(w2), .lock_i(lk[1:0]), .victim_o(v2), .no_victim_o(n2));

  way_victim_sel #(.NUM_WAYS(3), .NUM_LINES(LINES), .POLICY(POL_RANDOM), .LOCK_EN(1)) dut_rnd_i (
    .clk(clk), .rst(rst), .line_idx_i(idx), .access_i(acc), .fill_i(fill),
    .way_i(w3), .lock_i(lk[2:0]), .victim_o(v3), .no_victim_o(n3));

  way_victim_sel #(.NUM_WAYS(4), .NUM_LINES(LINES), .POLICY(POL_RANDOM), .LOCK_EN(0)) dut_nl_i (
    .clk(clk), .rst(rst), .line_idx_i(idx), .access_i(acc), .fill_i(fill),
    .way_i(w4), .lock_i(lk), .victim_o(vn), .no_victim_o(nn));

  way_victim_sel #(.NUM_WAYS(1), .NUM_LINES(LINES), .POLICY(POL_LRU), .LOCK_EN(1)) dut_dm_i (
    .clk(clk), .rst(rst), .line_idx_i(idx), .access_i(acc), .fill_i(fill),
    .way_i(1'b0), .lock_i(1'b0), .victim_o(vd), .no_victim_o(nd));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int first_free(input int a0, a1, a2, a3, n, input logic [3:0] l);
    int a [4];
    a = '{a0, a1, a2, a3};
    for (int k = 0; k < n; k++) if (!l[a[k]]) return a[k];
    return -1;
  endfunction

  task automatic touch(input int line, input int w);
    int p;
    p = 0;
    for (int k = 0; k < 4; k++) if (ord[line][k] == w) p = k;
    for (int k = p; k < 3; k++) ord[line][k] = ord[line][k+1];
    ord[line][3] = w;
  endtask

  // Called just after a falling edge; returns just after the next one
  task automatic step(input int i, input int a, input int f, input int x4,
                      input int x3, input int x2, input logic [3:0] l, input string tag);
    int e4, e2, e3, en;
    idx  = IW'(i);
    acc  = (a != 0);
    fill = (f != 0);
    w4   = 2'(x4);
    w3   = 2'(x3);
    w2   = 1'(x2);
    lk   = l;
    e4 = first_free(ord[i][0], ord[i][1], ord[i][2], ord[i][3], 4, l);
    e2 = first_free(lrrb[i], 1 - lrrb[i], 0, 0, 2, l);
    e3 = first_free(c3, (c3 + 1) % 3, (c3 + 2) % 3, 0, 3, l);
    en = c4;
    @(posedge clk);
    if (a != 0 || f != 0) touch(i, x4);
    if (f != 0) lrrb[i] = 1 - x2;
    c3 = (c3 + 1) % 3;
    c4 = (c4 + 1) % 4;
    @(negedge clk);
    chk({tag, " R5 R7 lru victim"}, int'(v4), (e4 < 0) ? 0 : e4);
    chk({tag, " R8 lru none"},      int'(n4), (e4 < 0) ? 1 : 0);
    chk({tag, " R4 R7 lrr victim"}, int'(v2), (e2 < 0) ? 0 : e2);
    chk({tag, " R8 lrr none"},      int'(n2), (e2 < 0) ? 1 : 0);
    chk({tag, " R3 R7 rnd victim"}, int'(v3), (e3 < 0) ? 0 : e3);
    chk({tag, " R8 rnd none"},      int'(n3), (e3 < 0) ? 1 : 0);
    chk({tag, " R9 nolock victim"}, int'(vn), en);
    chk({tag, " R9 nolock none"},   int'(nn), 0);
    chk({tag, " R1 direct victim"}, int'(vd), 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R6 reset outputs
    chk("R6 reset lru",  int'(v4), 0);
    chk("R6 reset none", int'(n4), 0);
    chk("R6 reset lrr",  int'(v2), 0);
    chk("R6 reset rnd",  int'(v3), 0);
    rst = 1'b0;
    for (int j = 0; j < LINES; j++) begin
      for (int k = 0; k < 4; k++) ord[j][k] = k;
      lrrb[j] = 0;
    end
    c3 = 0;
    c4 = 0;
    // R6 initial order, R2 latency of an update
    step(1, 0, 0, 0, 0, 0, 4'b0000, "R6");
    step(1, 1, 0, 0, 0, 0, 4'b0000, "R2");
    step(1, 0, 0, 0, 0, 0, 4'b0000, "R2");
    // R4 access alone leaves LRR bit, fill moves it
    step(2, 1, 0, 1, 0, 0, 4'b0000, "R4");
    step(2, 0, 1, 1, 0, 0, 4'b0000, "R4");
    step(2, 0, 0, 0, 0, 0, 4'b0000, "R4");
    // R7 lock fallbacks
    step(0, 0, 0, 0, 0, 0, 4'b0001, "R7");
    step(0, 0, 0, 0, 0, 0, 4'b0011, "R7");
    step(0, 0, 0, 0, 0, 0, 4'b0101, "R7");
    // R8 all locked, strobe still updates
    step(0, 1, 0, 0, 0, 0, 4'b1111, "R8");
    step(0, 0, 1, 1, 1, 1, 4'b1111, "R8");
    step(0, 0, 0, 0, 0, 0, 4'b0000, "R8");
    // R10 heavy traffic at line 3, line 4 untouched
    for (int k = 0; k < 4; k++) step(3, 1, 1, 3 - k, 0, 1, 4'b0000, "R10");
    step(4, 0, 0, 0, 0, 0, 4'b0000, "R10");
    step(3, 0, 0, 0, 0, 0, 4'b0000, "R10");
    // constrained random
    for (int k = 0; k < 400; k++) begin
      step(int'($urandom % LINES), int'($urandom % 3 == 0), int'($urandom % 4 == 0),
           int'($urandom % 4), int'($urandom % 3), int'($urandom % 2),
           4'($urandom & $urandom & $urandom), "rand");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog all act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule